// File: doc/BRIEF.md
# CEC Receive Bit-Timing Checker

This block sits on the receive side of a single-wire, open-drain consumer-electronics-control bus. It watches the bus level through a synchronizer and measures every start bit and data bit against a fixed timebase tick. Four kinds of timing fault are caught: a start bit whose low time or whole period is out of window, a data bit that stays low for too long, a data bit whose three samples near the nominal sample point disagree, and two falling edges that are too close together. Each fault sets its own sticky flag in a status byte.

For every data bit the block takes three samples, 1.00 ms, 1.05 ms and 1.10 ms after the bit's falling edge, and presents the majority value with a one-cycle strobe. When falling edges come closer than the minimum data bit period, the block answers on the bus itself: it pulls the line low for 3.6 ms (1.5 nominal bit periods) so that every other node sees the fault. Framing, addressing and acknowledge handling are left to the logic around it.

All durations are counted in ticks of a 50 us enable input. With the default parameters the windows are: start-bit low 70 to 78 ticks, start-bit period 86 to 94 ticks, data-bit low limit 34 ticks, minimum data-bit period 41 ticks, notification length 72 ticks, and return to idle after 60 ticks of high level in the data phase.

Top module: `cec_bit_timing_chk`

## Requirements
- R1: The line input passes through two flip-flops before edge detection; every duration is the number of `tick` pulses seen since the detected falling edge that started the current bit.
- R2: Each data bit is sampled on the 20th, 21st and 22nd tick after its falling edge; `dataBit` takes the majority of the three samples and `dataValid` is high for exactly one clock, the clock after the 22nd tick.
- R3: The sampling-error flag (`status[6]`) is set when `checkSampEn` is high at the third sample and the three samples of a data bit are not all equal; with `checkSampEn` low it stays clear.
- R4: The low-time-error flag (`status[5]`) is set when the line is still low at the 35th tick of a data bit (low for more than 34 ticks, 1.7 ms); a low time of exactly 34 ticks sets nothing.
- R5: The start-bit-error flag (`status[4]`) is set when the start bit's low time is outside 70..78 ticks or its period is outside 86..94 ticks; after a failed start bit the block returns to waiting for a start bit and produces no `dataValid` pulse.
- R6: The line-error flag (`status[0]`) is set when a data-phase falling edge comes fewer than 41 ticks after the previous one; a period of exactly 41 ticks is accepted.
- R7: On a line error `lineDriveLow` goes high in the clock after the edge is detected and stays high until the 72nd tick after it; edges on the line input during that time are ignored.
- R8: All four flags are sticky; a one-clock pulse on `clrRxDone` or on `clrRxErr` clears every flag in the next clock, and a clear wins over a set in the same clock.
- R9: A pulse on `rxEnable` clears only the line-error flag and leaves `status[6:4]` unchanged.
- R10: `status` bits 7 and 3:1 always read 0; after reset `status`, `dataBit`, `dataValid` and `lineDriveLow` are all 0.
- R11: In the data phase, a high level lasting until the 60th tick after the last falling edge ends the message, so the next falling edge is taken as a new start bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | One-clock timebase enable, one pulse per 50 us |
| lineIn | input | 1 | Raw bus level (1 = released/high) |
| checkSampEn | input | 1 | Enables the three-sample agreement check |
| clrRxDone | input | 1 | Clear pulse, clears all flags |
| clrRxErr | input | 1 | Clear pulse, clears all flags |
| rxEnable | input | 1 | Receive enable pulse, clears the line-error flag |
| lineDriveLow | output | 1 | 1 = pull the bus low (line-error notification) |
| status | output | 8 | Flags: [6] sampling, [5] low time, [4] start bit, [0] line; others 0 |
| dataBit | output | 1 | Majority value of the last data bit |
| dataValid | output | 1 | One-clock strobe marking a new `dataBit` |

## Verification
A change on `lineIn` reaches the edge detector three clock edges later, and every timing decision after that is taken on a `tick` edge, with the flag or strobe visible one clock after that edge; clears act one clock after the pulse. The bench therefore changes the line only on the falling clock edge right after a tick, waits whole numbers of ticks, and reads outputs on a falling clock edge, so that each threshold lands on a known tick: the 22nd tick for the sample strobe, the 35th for the low-time flag, the 72nd for the end of the notification. Flags are compared once the message has gone idle, which leaves every due result settled before it is read.

// File: rtl/cec_bit_timing_pkg.sv
package cec_bit_timing_pkg;

  // receiver phase
  typedef enum logic [2:0] {
    ST_IDLE       = 3'd0,
    ST_START_LOW  = 3'd1,
    ST_START_HIGH = 3'd2,
    ST_BIT        = 3'd3,
    ST_NOTIFY     = 3'd4
  } rxPhase_t;

  // strobes from control to datapath
  typedef struct packed {
    logic cntClr;
    logic samp0;
    logic samp1;
    logic samp2;
    logic setStart;
    logic setLow;
    logic setLine;
    logic drive;
  } ctlStrobes_t;

  // line events from datapath to control
  typedef struct packed {
    logic fall;
    logic rise;
    logic level;
  } lineEvents_t;

endpackage

// File: rtl/cec_bit_timing_dp.sv
module cec_bit_timing_dp
  import cec_bit_timing_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int CNT_W       = 8,
  parameter int VOTES       = 3
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             tick,
  input  logic             lineIn,
  input  logic             checkSampEn,
  input  logic             clrRxDone,
  input  logic             clrRxErr,
  input  logic             rxEnable,
  input  ctlStrobes_t      ctl,
  output lineEvents_t      ev,
  output logic [CNT_W-1:0] cnt,
  output logic [7:0]       status,
  output logic             dataBit,
  output logic             dataValid
);

  localparam int VOTE_W = $clog2(VOTES + 1);
  localparam logic [VOTE_W-1:0] MAJ = VOTE_W'((VOTES + 1) / 2);

  // synchronizer and edge detection
  logic [SYNC_STAGES-1:0] syncQ;
  logic                   lineDly;
  logic                   lineS;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      syncQ   <= '1;
      lineDly <= 1'b1;
    end else begin
      syncQ   <= {syncQ[SYNC_STAGES-2:0], lineIn};
      lineDly <= lineS;
    end
  end

  assign lineS    = syncQ[SYNC_STAGES-1];
  assign ev.fall  = lineDly & ~lineS;
  assign ev.rise  = ~lineDly & lineS;
  assign ev.level = lineS;

  // tick counter since the last accepted falling edge, saturating
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cnt <= '0;
    end else if (ctl.cntClr) begin
      cnt <= '0;
    end else if (tick && (cnt != '1)) begin
      cnt <= cnt + 1'b1;
    end
  end

  // early samples; the last one is taken straight from the line
  logic [VOTES-2:0] early;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      early <= '0;
    end else begin
      if (ctl.samp0) early[0] <= lineS;
      if (ctl.samp1) early[1] <= lineS;
    end
  end

  logic [VOTES-1:0]  votes;
  logic [VOTE_W-1:0] ones;
  logic              majority;
  logic              agree;

  assign votes = {lineS, early};

  always_comb begin
    ones = '0;
    for (int i = 0; i < VOTES; i++) begin
      ones = ones + VOTE_W'(votes[i]);
    end
  end

  assign majority = (ones >= MAJ);
  assign agree    = (votes == '0) || (votes == '1);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      dataBit   <= 1'b0;
      dataValid <= 1'b0;
    end else begin
      dataValid <= ctl.samp2;
      if (ctl.samp2) dataBit <= majority;
    end
  end

  // sticky flags, clear before set
  logic clrAll;
  logic sampErr, lowErr, startErr, lineErr;

  assign clrAll = clrRxDone | clrRxErr;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sampErr  <= 1'b0;
      lowErr   <= 1'b0;
      startErr <= 1'b0;
      lineErr  <= 1'b0;
    end else begin
      if (clrAll)                                    sampErr <= 1'b0;
      else if (ctl.samp2 && checkSampEn && !agree)   sampErr <= 1'b1;

      if (clrAll)            lowErr <= 1'b0;
      else if (ctl.setLow)   lowErr <= 1'b1;

      if (clrAll)             startErr <= 1'b0;
      else if (ctl.setStart)  startErr <= 1'b1;

      if (clrAll || rxEnable) lineErr <= 1'b0;
      else if (ctl.setLine)   lineErr <= 1'b1;
    end
  end

  assign status = {1'b0, sampErr, lowErr, startErr, 3'b000, lineErr};

endmodule

// File: rtl/cec_bit_timing_ctrl.sv
module cec_bit_timing_ctrl
  import cec_bit_timing_pkg::*;
#(
  parameter int CNT_W      = 8,
  parameter int SAMP_FIRST = 20,
  parameter int LOW_MAX    = 34,
  parameter int SL_MIN     = 70,
  parameter int SL_MAX     = 78,
  parameter int SP_MIN     = 86,
  parameter int SP_MAX     = 94,
  parameter int BIT_MIN    = 41,
  parameter int NOTIFY_LEN = 72,
  parameter int IDLE_LEN   = 60
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             tick,
  input  lineEvents_t      ev,
  input  logic [CNT_W-1:0] cnt,
  output ctlStrobes_t      ctl
);

  // "count moves to N" is tested as tick with count N-1
  localparam logic [CNT_W-1:0] S0_M1     = CNT_W'(SAMP_FIRST - 1);
  localparam logic [CNT_W-1:0] S1_M1     = CNT_W'(SAMP_FIRST);
  localparam logic [CNT_W-1:0] S2_M1     = CNT_W'(SAMP_FIRST + 1);
  localparam logic [CNT_W-1:0] LOW_C     = CNT_W'(LOW_MAX);
  localparam logic [CNT_W-1:0] SLMIN_C   = CNT_W'(SL_MIN);
  localparam logic [CNT_W-1:0] SLMAX_C   = CNT_W'(SL_MAX);
  localparam logic [CNT_W-1:0] SPMIN_C   = CNT_W'(SP_MIN);
  localparam logic [CNT_W-1:0] SPMAX_C   = CNT_W'(SP_MAX);
  localparam logic [CNT_W-1:0] BITMIN_C  = CNT_W'(BIT_MIN);
  localparam logic [CNT_W-1:0] NOTIFY_M1 = CNT_W'(NOTIFY_LEN - 1);
  localparam logic [CNT_W-1:0] IDLE_M1   = CNT_W'(IDLE_LEN - 1);

  rxPhase_t phase, phaseNext;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) phase <= ST_IDLE;
    else       phase <= phaseNext;
  end

  always_comb begin
    phaseNext  = phase;
    ctl        = '0;
    ctl.drive  = (phase == ST_NOTIFY);
    ctl.cntClr = ev.fall && (phase != ST_NOTIFY);

    case (phase)
      ST_IDLE: begin
        if (ev.fall) phaseNext = ST_START_LOW;
      end

      ST_START_LOW: begin
        if (ev.rise) begin
          if ((cnt < SLMIN_C) || (cnt > SLMAX_C)) begin
            ctl.setStart = 1'b1;
            phaseNext    = ST_IDLE;
          end else begin
            phaseNext = ST_START_HIGH;
          end
        end else if (tick && (cnt == SLMAX_C) && !ev.level) begin
          ctl.setStart = 1'b1;
          phaseNext    = ST_IDLE;
        end
      end

      ST_START_HIGH: begin
        if (ev.fall) begin
          if ((cnt < SPMIN_C) || (cnt > SPMAX_C)) begin
            ctl.setStart = 1'b1;
            phaseNext    = ST_IDLE;
          end else begin
            phaseNext = ST_BIT;
          end
        end else if (tick && (cnt == SPMAX_C)) begin
          ctl.setStart = 1'b1;
          phaseNext    = ST_IDLE;
        end
      end

      ST_BIT: begin
        if (ev.fall) begin
          if (cnt < BITMIN_C) begin
            ctl.setLine = 1'b1;
            phaseNext   = ST_NOTIFY;
          end
        end else if (tick) begin
          ctl.samp0  = (cnt == S0_M1);
          ctl.samp1  = (cnt == S1_M1);
          ctl.samp2  = (cnt == S2_M1);
          ctl.setLow = (cnt == LOW_C) && !ev.level;
          if (ev.level && (cnt >= IDLE_M1)) phaseNext = ST_IDLE;
        end
      end

      ST_NOTIFY: begin
        if (tick && (cnt == NOTIFY_M1)) phaseNext = ST_IDLE;
      end

      default: phaseNext = ST_IDLE;
    endcase
  end

endmodule

// File: rtl/cec_bit_timing_chk.sv
module cec_bit_timing_chk
  import cec_bit_timing_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int CNT_W       = 8,
  parameter int SAMP_FIRST  = 20,
  parameter int LOW_MAX     = 34,
  parameter int SL_MIN      = 70,
  parameter int SL_MAX      = 78,
  parameter int SP_MIN      = 86,
  parameter int SP_MAX      = 94,
  parameter int BIT_MIN     = 41,
  parameter int NOTIFY_LEN  = 72,
  parameter int IDLE_LEN    = 60
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       tick,
  input  logic       lineIn,
  input  logic       checkSampEn,
  input  logic       clrRxDone,
  input  logic       clrRxErr,
  input  logic       rxEnable,
  output logic       lineDriveLow,
  output logic [7:0] status,
  output logic       dataBit,
  output logic       dataValid
);

  ctlStrobes_t      ctl;
  lineEvents_t      ev;
  logic [CNT_W-1:0] cnt;

  cec_bit_timing_dp #(
    .SYNC_STAGES(SYNC_STAGES),
    .CNT_W      (CNT_W),
    .VOTES      (3)
  ) i_dp (
    .clk        (clk),
    .rstN       (rstN),
    .tick       (tick),
    .lineIn     (lineIn),
    .checkSampEn(checkSampEn),
    .clrRxDone  (clrRxDone),
    .clrRxErr   (clrRxErr),
    .rxEnable   (rxEnable),
    .ctl        (ctl),
    .ev         (ev),
    .cnt        (cnt),
    .status     (status),
    .dataBit    (dataBit),
    .dataValid  (dataValid)
  );

  cec_bit_timing_ctrl #(
    .CNT_W     (CNT_W),
    .SAMP_FIRST(SAMP_FIRST),
    .LOW_MAX   (LOW_MAX),
    .SL_MIN    (SL_MIN),
    .SL_MAX    (SL_MAX),
    .SP_MIN    (SP_MIN),
    .SP_MAX    (SP_MAX),
    .BIT_MIN   (BIT_MIN),
    .NOTIFY_LEN(NOTIFY_LEN),
    .IDLE_LEN  (IDLE_LEN)
  ) i_ctrl (
    .clk (clk),
    .rstN(rstN),
    .tick(tick),
    .ev  (ev),
    .cnt (cnt),
    .ctl (ctl)
  );

  assign lineDriveLow = ctl.drive;

endmodule

// File: rtl/cec_bit_timing_sva.sv
module cec_bit_timing_sva (
  input logic       clk,
  input logic       rstN,
  input logic       tick,
  input logic       clrRxDone,
  input logic       clrRxErr,
  input logic       rxEnable,
  input logic       lineDriveLow,
  input logic [7:0] status,
  input logic       dataValid
);

  // R8
  flags_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    ($fell(status[6]) || $fell(status[5]) || $fell(status[4])) |-> $past(clrRxDone || clrRxErr));

  // R9
  line_flag_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(status[0]) |-> $past(clrRxDone || clrRxErr || rxEnable));

  // R8
  clear_empties_chk: assert property (@(posedge clk) disable iff (!rstN)
    (clrRxDone || clrRxErr) |=> (status == 8'h00));

  // R2
  valid_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    dataValid |=> !dataValid);

  // R7
  notify_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (lineDriveLow && !tick) |=> lineDriveLow);

  // R6
  notify_flag_chk: assert property (@(posedge clk) disable iff (!rstN)
    ($rose(lineDriveLow) && !$past(clrRxDone || clrRxErr || rxEnable)) |-> status[0]);

endmodule

bind cec_bit_timing_chk cec_bit_timing_sva i_sva (
  .clk         (clk),
  .rstN        (rstN),
  .tick        (tick),
  .clrRxDone   (clrRxDone),
  .clrRxErr    (clrRxErr),
  .rxEnable    (rxEnable),
  .lineDriveLow(lineDriveLow),
  .status      (status),
  .dataValid   (dataValid)
);

// File: tb/test_cec_bit_timing_chk.sv
module test_cec_bit_timing_chk;

  localparam int TP = 6;          // clocks per tick
  localparam int WD = 195000;     // watchdog limit in clocks

  logic clk = 1'b0;
  always #2 clk = ~clk;           // 250 MHz

  logic       rstN = 1'b0;
  logic       tick = 1'b0;
  logic       lineIn = 1'b1;
  logic       checkSampEn = 1'b0;
  logic       clrRxDone = 1'b0;
  logic       clrRxErr = 1'b0;
  logic       rxEnable = 1'b0;
  logic       lineDriveLow;
  logic [7:0] status;
  logic       dataBit;
  logic       dataValid;

  cec_bit_timing_chk i_cec_bit_timing_chk (
    .clk         (clk),
    .rstN        (rstN),
    .tick        (tick),
    .lineIn      (lineIn),
    .checkSampEn (checkSampEn),
    .clrRxDone   (clrRxDone),
    .clrRxErr    (clrRxErr),
    .rxEnable    (rxEnable),
    .lineDriveLow(lineDriveLow),
    .status      (status),
    .dataBit     (dataBit),
    .dataValid   (dataValid)
  );

  int checks = 0;
  int fails = 0;
  int cycles = 0;
  int tc = 0;
  int rxCount = 0;
  logic rxBits [64];
  int bL [16];
  int bP [16];
  int nb = 0;
  bit clrSel = 1'b0;

  always @(negedge clk) begin
    if (tc == TP - 1) begin tc = 0; tick = 1'b1; end
    else begin tc++; tick = 1'b0; end
  end

  always @(negedge clk) begin
    if (rstN && dataValid) begin
      if (rxCount < 64) rxBits[rxCount] = dataBit;
      rxCount++;
    end
  end

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles == WD) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual %0d cycles expected completion earlier", cycles);
      summary();
      $finish;
    end
  end

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic waitTicks(int n);
    for (int i = 0; i < n; i++) begin
      do @(posedge clk); while (!tick);
    end
    @(negedge clk);
  endtask

  task automatic sendLevel(int lowT, int perT);
    lineIn = 1'b0;
    waitTicks(lowT);
    lineIn = 1'b1;
    waitTicks(perT - lowT);
  endtask

  // expected sample k of a bit with low time L
  function automatic logic sampleOf(int L, int k);
    return (L < 20 + k);
  endfunction

  function automatic logic majOf(int L);
    int s;
    s = 0;
    for (int k = 0; k < 3; k++) s += int'(sampleOf(L, k));
    return (s >= 2);
  endfunction

  function automatic logic disagree(int L);
    return !((sampleOf(L, 0) == sampleOf(L, 1)) && (sampleOf(L, 1) == sampleOf(L, 2)));
  endfunction

  task automatic clearFlags(string tag);
    if (clrSel) clrRxDone = 1'b1; else clrRxErr = 1'b1;
    @(negedge clk);
    clrRxDone = 1'b0;
    clrRxErr  = 1'b0;
    clrSel = !clrSel;
    check({tag, " R8 clear"}, 32'(status), 32'h00);
  endtask

  // start bit, nb data bits from bL/bP, then idle
  task automatic runMsg(int sl, int sp, bit en, string tag);
    logic [7:0] exp;
    exp = 8'h00;
    waitTicks(1);
    checkSampEn = en;
    rxCount = 0;
    sendLevel(sl, sp);
    for (int i = 0; i < nb; i++) begin
      sendLevel(bL[i], bP[i]);
      if (en && disagree(bL[i])) exp[6] = 1'b1;
      if (bL[i] > 34) exp[5] = 1'b1;
    end
    waitTicks(70);
    check({tag, " R2 bit count"}, 32'(rxCount), 32'(nb));
    for (int i = 0; i < nb && i < 64; i++) begin
      check({tag, " R2 bit value"}, 32'(rxBits[i]), 32'(majOf(bL[i])));
    end
    check({tag, " R3 R4 R10 R11 status"}, 32'(status), 32'(exp));
    clearFlags(tag);
  endtask

  task automatic startFault(int sl, int sp, string tag);
    waitTicks(1);
    rxCount = 0;
    sendLevel(sl, sp);
    sendLevel(12, 122);
    check({tag, " R5 start flag"}, 32'(status), 32'h10);
    check({tag, " R5 no data"}, 32'(rxCount), 32'd0);
    clearFlags(tag);
  endtask

  initial begin
    void'($urandom(32'h5eed_c0de));
    repeat (5) @(negedge clk);
    // R10 reset state
    check("R10 reset status", 32'(status), 32'h00);
    check("R10 reset drive", 32'(lineDriveLow), 32'd0);
    check("R10 reset valid", 32'(dataValid), 32'd0);
    check("R10 reset bit", 32'(dataBit), 32'd0);
    rstN = 1'b1;
    waitTicks(3);

    // R1 R6 shortest accepted period and window edges
    nb = 2; bL[0] = 12; bP[0] = 41; bL[1] = 30; bP[1] = 48;
    runMsg(70, 86, 1'b1, "R1 R6 min period");
    // R1 R4 low time of exactly 34 ticks
    nb = 1; bL[0] = 34; bP[0] = 48;
    runMsg(78, 94, 1'b1, "R1 R4 low 34");
    // R4 low time of 35 ticks
    nb = 1; bL[0] = 35; bP[0] = 48;
    runMsg(74, 90, 1'b1, "R4 low 35");
    // R3 disagreement with check enabled
    nb = 1; bL[0] = 20; bP[0] = 48;
    runMsg(74, 90, 1'b1, "R3 enabled");
    // R3 disagreement with check disabled
    nb = 1; bL[0] = 21; bP[0] = 48;
    runMsg(74, 90, 1'b0, "R3 disabled");

    // R5 start-bit faults
    startFault(69, 90, "R5 low short");
    startFault(79, 90, "R5 low long");
    startFault(74, 85, "R5 period short");
    startFault(74, 95, "R5 period long");

    // R6 R7 R9 line error and notification
    waitTicks(1);
    rxCount = 0;
    checkSampEn = 1'b1;
    sendLevel(74, 90);
    sendLevel(36, 48);
    sendLevel(12, 40);
    lineIn = 1'b0;
    waitTicks(2);
    check("R6 R7 drive on", 32'(lineDriveLow), 32'd1);
    waitTicks(10);
    lineIn = 1'b1;
    waitTicks(18);
    lineIn = 1'b0;
    waitTicks(6);
    lineIn = 1'b1;
    waitTicks(35);
    check("R7 drive at tick 71", 32'(lineDriveLow), 32'd1);
    waitTicks(1);
    check("R7 drive released", 32'(lineDriveLow), 32'd0);
    check("R6 status", 32'(status), 32'h21);
    check("R2 notify bits", 32'(rxCount), 32'd2);
    check("R2 notify bit0", 32'(rxBits[0]), 32'd0);
    check("R2 notify bit1", 32'(rxBits[1]), 32'd1);
    waitTicks(5);
    rxEnable = 1'b1;
    @(negedge clk);
    rxEnable = 1'b0;
    check("R9 enable clears line only", 32'(status), 32'h20);
    clearFlags("R9");

    // random messages
    for (int m = 0; m < 16; m++) begin
      int sl, sp, hi;
      sl = $urandom_range(78, 70);
      sp = $urandom_range(94, 86);
      nb = $urandom_range(6, 1);
      for (int i = 0; i < nb; i++) begin
        bL[i] = $urandom_range(40, 8);
        hi = (bL[i] + 8 > 44) ? bL[i] + 8 : 44;
        bP[i] = hi + $urandom_range(10, 0);
      end
      runMsg(sl, sp, 1'($urandom_range(1, 0)), "R11 random");
    end

    summary();
    $finish;
  end

endmodule